// File: doc/BRIEF.md
# Programmable Slew Reference Ramp

This block generates the digital set-point that feeds the reference of a core-voltage buck regulator. It holds a programmed target voltage and moves its output reference toward that target one step per time-base tick. The step size depends on a selectable slew rate. The output is expressed in 0.1 mV units, so 1.30 V appears as 13000. A 4-bit voltage code sets the target, and a 2-bit slew code selects one of four ramp rates.

The block has two control modes. In command mode, the code and the rate are captured only when a new-command strobe is pulsed. In pin mode, the target follows the voltage code pins continuously, and every move uses the fixed start-up rate. The ramp runs only while the supply power-on-reset is good and enable is high. Whenever either is low, the reference is zero. When both are high again, the reference climbs from zero at the start-up rate back to the last programmed target.

The time base is a tick derived from the system clock every `TICK_CYCLES` cycles, with one tick standing for one microsecond. A rate of r mV/µs therefore becomes a step of r×10 units per tick. Two flags report the ramp state: a busy flag while the ramp is moving and an at-target flag once it has landed.

Top module: `slew_ref_ramp`

## Requirements
- R1: The target in 0.1 mV units is 8500 + 500 × code (code 0 gives 0.85 V, code 15 gives 1.60 V). `at_target` is high exactly in the cycles where the block is active and `ref_out` equals the target.
- R2: After start-up in command mode, each tick moves `ref_out` by a step set by the stored slew code: 5 units for 2'b00, 10 for 2'b01, 25 for 2'b10 and 50 for 2'b11. A tick occurs every `TICK_CYCLES` clocks while the block is active.
- R3: When `por_ok` or `en` is low, `ref_out` is 0 and both flags are low from the next clock edge. No ramping happens until both are high.
- R4: After activation, `ref_out` rises from 0 by 10 units per tick, whatever slew code is stored, until it first reaches the target.
- R5: With `vid_mode` high, the target follows `volt_code` every cycle. Every step is 10 units per tick, whatever the slew code.
- R6: With `vid_mode` low, the voltage code and slew code are captured only in a cycle with `cmd_strobe` high. Changes on those inputs at other times have no effect on `ref_out`.
- R7: After an enable or power-on-reset cycle, the ramp returns to the last programmed target. That target is not reset to the default.
- R8: A new target that arrives mid-ramp redirects the ramp from the present `ref_out`.
- R9: The final step is clamped so that `ref_out` lands exactly on the target and never passes it. Once there, it holds.
- R10: After reset, the stored code is 9 (1.30 V) and the stored slew code is 2'b01.
- R11: `ramp_busy` is high exactly when the block is active and `ref_out` differs from the target. `ramp_busy` and `at_target` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | Supply power-on-reset good |
| en | input | 1 | Regulator enable |
| vid_mode | input | 1 | 1: target from pins at the fixed rate; 0: command mode |
| cmd_strobe | input | 1 | Captures voltage and slew codes in command mode |
| volt_code | input | CODE_W | Voltage code |
| slew_code | input | 2 | Slew rate select |
| ref_out | output | 16 | Reference set-point in 0.1 mV units |
| ramp_busy | output | 1 | Ramp moving toward target |
| at_target | output | 1 | Reference equals target |

## Verification
The assertions check several properties on every cycle:
- the zero output while the block is inactive;
- the exclusivity of the two flags;
- that the at-target flag only coincides with the exact coded voltage;
- the per-step bound of 50 units, tightened to 10 units during start-up and in pin mode;
- that the reference never crosses the target it is moving toward.

The exact step size for each slew code, the capture of codes only on a strobe, the redirect from a mid-ramp value, and the default and remembered targets across an enable cycle depend on the stimulus history. Only the bench scenarios can show these, which is why they compare `ref_out` at tick-aligned points against values worked out from the requirements.

// File: rtl/slew_ref_pkg.sv
package slew_ref_pkg;
  localparam int unsigned REF_W    = 16;
  localparam int unsigned SLEW_W   = 2;
  localparam int unsigned BASE_U   = 8500;
  localparam int unsigned STEP_U   = 500;
  localparam int unsigned BOOT_INC = 10;

  typedef logic [REF_W-1:0]  ref_t;
  typedef logic [SLEW_W-1:0] slew_t;

  // Target set-point in 0.1 mV units for a voltage code
  function automatic ref_t code_to_ref(input int unsigned code);
    return ref_t'(BASE_U + STEP_U * code);
  endfunction

  // Step per microsecond tick in 0.1 mV units for a slew select
  function automatic ref_t rate_inc(input slew_t sel);
    ref_t inc;
    case (sel)
      2'b00:   inc = ref_t'(5);
      2'b01:   inc = ref_t'(10);
      2'b10:   inc = ref_t'(25);
      default: inc = ref_t'(50);
    endcase
    return inc;
  endfunction
endpackage

// File: rtl/slew_ref_tick.sv
module slew_ref_tick #(
  parameter int unsigned TICK_CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/slew_ref_target.sv
module slew_ref_target
  import slew_ref_pkg::*;
#(
  parameter int unsigned CODE_W       = 4,
  parameter int unsigned DEFAULT_CODE = 9,
  parameter int unsigned DEFAULT_SLEW = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vid_mode,
  input  logic              cmd_strobe,
  input  logic [CODE_W-1:0] volt_code,
  input  slew_t             slew_code,
  output logic [CODE_W-1:0] code_d,
  output logic [CODE_W-1:0] code_q,
  output slew_t             slew_q
);
  slew_t slew_d;

  always_comb begin
    code_d = code_q;
    slew_d = slew_q;
    if (vid_mode) begin
      code_d = volt_code;
    end else if (cmd_strobe) begin
      code_d = volt_code;
      slew_d = slew_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= CODE_W'(DEFAULT_CODE);
      slew_q <= SLEW_W'(DEFAULT_SLEW);
    end else begin
      code_q <= code_d;
      slew_q <= slew_d;
    end
  end
endmodule

// File: rtl/slew_ref_core.sv
module slew_ref_core
  import slew_ref_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic tick,
  input  ref_t tgt,
  input  ref_t inc,
  output ref_t ref_q,
  output logic at_q,
  output logic busy_q,
  output logic boot_q
);
  ref_t next_ref;
  ref_t gap;

  always_comb begin
    next_ref = ref_q;
    gap      = '0;
    if (!active) begin
      next_ref = '0;
    end else if (tick) begin
      if (ref_q < tgt) begin
        gap      = tgt - ref_q;
        next_ref = (gap <= inc) ? tgt : ref_q + inc;
      end else if (ref_q > tgt) begin
        gap      = ref_q - tgt;
        next_ref = (gap <= inc) ? tgt : ref_q - inc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= '0;
      at_q   <= 1'b0;
      busy_q <= 1'b0;
      boot_q <= 1'b1;
    end else begin
      ref_q  <= next_ref;
      at_q   <= active && (next_ref == tgt);
      busy_q <= active && (next_ref != tgt);
      if (!active) boot_q <= 1'b1;
      else if (next_ref == tgt) boot_q <= 1'b0;
    end
  end
endmodule

// File: rtl/slew_ref_ramp.sv
module slew_ref_ramp
  import slew_ref_pkg::*;
#(
  parameter int unsigned CODE_W       = 4,
  parameter int unsigned TICK_CYCLES  = 100,
  parameter int unsigned DEFAULT_CODE = 9,
  parameter int unsigned DEFAULT_SLEW = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_ok,
  input  logic              en,
  input  logic              vid_mode,
  input  logic              cmd_strobe,
  input  logic [CODE_W-1:0] volt_code,
  input  logic [1:0]        slew_code,
  output logic [15:0]       ref_out,
  output logic              ramp_busy,
  output logic              at_target
);
  logic              active;
  logic              tick;
  logic [CODE_W-1:0] tgt_code_d;
  logic [CODE_W-1:0] tgt_code_q;
  slew_t             slew_q;
  ref_t              tgt;
  ref_t              inc;
  ref_t              ref_q;
  logic              boot_q;

  assign active = por_ok && en;

  slew_ref_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (active),
    .tick(tick)
  );

  slew_ref_target #(
    .CODE_W      (CODE_W),
    .DEFAULT_CODE(DEFAULT_CODE),
    .DEFAULT_SLEW(DEFAULT_SLEW)
  ) u_target (
    .clk       (clk),
    .rst       (rst),
    .vid_mode  (vid_mode),
    .cmd_strobe(cmd_strobe),
    .volt_code (volt_code),
    .slew_code (slew_code),
    .code_d    (tgt_code_d),
    .code_q    (tgt_code_q),
    .slew_q    (slew_q)
  );

  assign tgt = code_to_ref(int'(tgt_code_d));
  assign inc = (boot_q || vid_mode) ? ref_t'(BOOT_INC) : rate_inc(slew_q);

  slew_ref_core u_core (
    .clk   (clk),
    .rst   (rst),
    .active(active),
    .tick  (tick),
    .tgt   (tgt),
    .inc   (inc),
    .ref_q (ref_q),
    .at_q  (at_target),
    .busy_q(ramp_busy),
    .boot_q(boot_q)
  );

  assign ref_out = ref_q;
endmodule

// File: rtl/slew_ref_ramp_chk.sv
module slew_ref_ramp_chk
  import slew_ref_pkg::*;
#(
  parameter int unsigned CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              por_ok,
  input logic              en,
  input logic              vid_mode,
  input logic [15:0]       ref_out,
  input logic              ramp_busy,
  input logic              at_target,
  input logic [CODE_W-1:0] code_q,
  input logic              boot
);
  int tgt_i;
  logic act;
  assign tgt_i = int'(BASE_U) + int'(STEP_U) * int'(code_q);
  assign act   = por_ok && en;

  // R3: inactive forces zero output and clear flags on the next edge
  p_off_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !act |=> (ref_out == 16'd0 && !ramp_busy && !at_target));

  // R11: flags never both high
  p_flags_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(ramp_busy && at_target));

  // R1: at-target only on the exact coded voltage
  p_land_exact_r1: assert property (@(posedge clk) disable iff (rst)
    at_target |-> int'(ref_out) == tgt_i);

  // R2: no step exceeds the fastest rate
  p_step_max_r2: assert property (@(posedge clk) disable iff (rst)
    (act && $past(act)) |->
      ((int'(ref_out) - int'($past(ref_out)) <= 50) &&
       (int'(ref_out) - int'($past(ref_out)) >= -50)));

  // R4: start-up steps are at most 10 units
  p_boot_rate_r4: assert property (@(posedge clk) disable iff (rst)
    (act && $past(act) && $past(boot)) |->
      ((int'(ref_out) - int'($past(ref_out)) <= 10) &&
       (int'(ref_out) - int'($past(ref_out)) >= -10)));

  // R5: pin mode steps are at most 10 units
  p_pin_rate_r5: assert property (@(posedge clk) disable iff (rst)
    (act && $past(act) && vid_mode && $past(vid_mode)) |->
      ((int'(ref_out) - int'($past(ref_out)) <= 10) &&
       (int'(ref_out) - int'($past(ref_out)) >= -10)));

  // R9: rising ramp never passes the target it moves toward
  p_no_overshoot_r9: assert property (@(posedge clk) disable iff (rst)
    (act && $past(act) && int'($past(ref_out)) <= tgt_i) |-> int'(ref_out) <= tgt_i);

  // R9: once landed with an unchanged target the reference holds
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (at_target && $past(at_target) && $stable(code_q)) |-> $stable(ref_out));
endmodule

bind slew_ref_ramp slew_ref_ramp_chk #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .por_ok   (por_ok),
  .en       (en),
  .vid_mode (vid_mode),
  .ref_out  (ref_out),
  .ramp_busy(ramp_busy),
  .at_target(at_target),
  .code_q   (tgt_code_q),
  .boot     (boot_q)
);

// File: tb/slew_ref_ramp_tb.sv
module slew_ref_ramp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T          = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        por_ok = 1'b1;
  logic        en = 1'b0;
  logic        vid_mode = 1'b0;
  logic        cmd_strobe = 1'b0;
  logic [3:0]  volt_code = 4'd0;
  logic [1:0]  slew_code = 2'd0;
  logic [15:0] ref_out;
  logic        ramp_busy;
  logic        at_target;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    string       tag;
    logic [15:0] ref_v;
    logic        at_v;
    logic        busy_v;
  } exp_t;
  exp_t exp_q[$];
  event sample_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  slew_ref_ramp #(.CODE_W(4), .TICK_CYCLES(T)) u_dut (
    .clk(clk), .rst(rst), .por_ok(por_ok), .en(en), .vid_mode(vid_mode),
    .cmd_strobe(cmd_strobe), .volt_code(volt_code), .slew_code(slew_code),
    .ref_out(ref_out), .ramp_busy(ramp_busy), .at_target(at_target)
  );

  // Driver side: push an expected item and wake the monitor
  task automatic expect_now(input string tag, input int r, input bit at, input bit busy);
    exp_t e;
    e.tag = tag; e.ref_v = 16'(r); e.at_v = at; e.busy_v = busy;
    exp_q.push_back(e);
    -> sample_ev;
  endtask

  // Monitor side: pop and compare against the outputs
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (ref_out !== e.ref_v || at_target !== e.at_v || ramp_busy !== e.busy_v) begin
          n_fail++;
          $display("FAIL %s: ref=%0d at=%0b busy=%0b expected ref=%0d at=%0b busy=%0b",
                   e.tag, ref_out, at_target, ramp_busy, e.ref_v, e.at_v, e.busy_v);
        end
      end
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n * T) @(negedge clk);
  endtask

  // Command strobe: one tick of time elapses, new target applies on it
  task automatic cmd(input logic [3:0] c, input logic [1:0] s);
    volt_code = c; slew_code = s; cmd_strobe = 1'b1;
    @(negedge clk);
    cmd_strobe = 1'b0;
    repeat (T - 1) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_now("R3 reset idle", 0, 0, 0);

    // Start-up ramp to default target (R10, R4)
    en = 1'b1;
    wait_ticks(5);
    expect_now("R4 startup step", 50, 0, 1);
    wait_ticks(1294);
    expect_now("R4 startup near end", 12990, 0, 1);
    wait_ticks(1);
    expect_now("R10 default 1.30V", 13000, 1, 0);

    // Redirect mid-ramp with clamped final step (R8, R9)
    cmd(4'd12, 2'b00);
    expect_now("R2 slew 00", 13005, 0, 1);
    wait_ticks(2);
    expect_now("R2 slew 00 run", 13015, 0, 1);
    cmd(4'd10, 2'b11);
    expect_now("R8 redirect from current", 13065, 0, 1);
    wait_ticks(8);
    expect_now("R9 before clamp", 13465, 0, 1);
    wait_ticks(1);
    expect_now("R9 clamped landing", 13500, 1, 0);
    wait_ticks(2);
    expect_now("R9 holds", 13500, 1, 0);

    // Rate table (R2) and target formula (R1)
    cmd(4'd0, 2'b11);
    expect_now("R2 slew 11 down", 13450, 0, 1);
    wait_ticks(99);
    expect_now("R1 code 0 = 8500", 8500, 1, 0);
    cmd(4'd1, 2'b10);
    expect_now("R2 slew 10", 8525, 0, 1);
    wait_ticks(19);
    expect_now("R1 code 1 = 9000", 9000, 1, 0);
    cmd(4'd3, 2'b00);
    expect_now("R2 slew 00 up", 9005, 0, 1);
    wait_ticks(199);
    expect_now("R1 code 3 = 10000", 10000, 1, 0);
    cmd(4'd9, 2'b01);
    expect_now("R2 slew 01", 10010, 0, 1);
    wait_ticks(299);
    expect_now("R1 code 9", 13000, 1, 0);

    // Pin mode: target from pins, fixed rate (R5)
    vid_mode = 1'b1; volt_code = 4'd11; slew_code = 2'b11;
    wait_ticks(1);
    expect_now("R5 pin rate", 13010, 0, 1);
    wait_ticks(99);
    expect_now("R5 pin target", 14000, 1, 0);
    volt_code = 4'd10;
    wait_ticks(1);
    expect_now("R5 pin follows", 13990, 0, 1);
    volt_code = 4'd11;
    wait_ticks(1);
    expect_now("R5 pin back", 14000, 1, 0);
    vid_mode = 1'b0;

    // Inputs without strobe ignored (R6)
    volt_code = 4'd2; slew_code = 2'b00;
    wait_ticks(3);
    expect_now("R6 no strobe no change", 14000, 1, 0);
    cmd(4'd11, 2'b11);
    expect_now("R6 same target", 14000, 1, 0);

    // Disable / POR cycle (R3) and return to last target (R7, R4)
    en = 1'b0;
    @(negedge clk);
    expect_now("R3 disable zero", 0, 0, 0);
    por_ok = 1'b0;
    en = 1'b1;
    repeat (10) @(negedge clk);
    expect_now("R3 por low holds zero", 0, 0, 0);
    por_ok = 1'b1;
    wait_ticks(3);
    expect_now("R4 restart at boot rate", 30, 0, 1);
    wait_ticks(1396);
    expect_now("R7 near last target", 13990, 0, 1);
    wait_ticks(1);
    expect_now("R7 last target restored", 14000, 1, 0);
    cmd(4'd10, 2'b11);
    expect_now("R2 stored rate after boot", 13950, 0, 1);
    wait_ticks(9);
    expect_now("R1 code 10", 13500, 1, 0);

    #1;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule